// File: doc/BRIEF.md
# Interrupt Priority Selector with Power-Save Wake

This block keeps a vector of pending interrupt requests and, every cycle, picks the single highest-priority request that is allowed through by the processor's current state. It also follows a halted (power-saving) state. While halted, the rules for which sources may be taken change. The result appears as a registered source code and a valid flag. A core uses this flag to decide whether to take an interrupt, and it pulses an acknowledge when it does.

Source index sets the priority, and a lower index wins. Index 0 is machine check, 1 is hypervisor decrementer, 2 is hypervisor virtualisation, 3 is external and 4 is decrementer. Indices 5 and up are further low-priority sources. When an acknowledge arrives, the block normally clears the pending bit of the selected source. There is one exception: a core woken from power-save with its external-enable bit off resumes at the next instruction. In that case nothing is delivered and the request stays pending. The block flags this with a one-cycle wake-skip pulse.

Top module: `irq_prio_wake`

## Requirements
- R1: A one-cycle pulse on a `req_set` bit sets that pending bit on the next edge. An acknowledge while `sel_valid` is high clears the bit of the selected source. A set and a clear of the same bit in one cycle leave it set.
- R2: `sel_valid`/`sel_code` are registered from the pending vector and state of the previous cycle. `sel_code` is the index of the winning source, where a lower index has higher priority. With no qualifying source, `sel_valid` is 0 and `sel_code` is 0.
- R3: Machine check (index 0) wins whenever it is pending, whatever the enable bits, except while halted with `exit_ctl` set.
- R4: The effective enable is `ext_en` OR `resume_reset`, and it is forced to 1 while halted with `exit_ctl` clear.
- R5: The hypervisor decrementer (index 1) qualifies only when `hdec_enable` is 1 and either the effective enable is 1 or `hyp_state` is 0.
- R6: The hypervisor virtualisation source (index 2) follows the rule of R5, gated by `hvirt_enable` instead.
- R7: The external source (index 3) qualifies when either of two conditions holds. The first is that the effective enable is 1 and delivery is not blocked; delivery is blocked when `ext_hyp_block`=1, `hyp_state`=1 and `prob_state`=0. The second is that the HAS_HV parameter is 1, `hyp_state`=0 and `ext_route_os`=0.
- R8: Index 4 and all higher indices qualify only when the effective enable is 1.
- R9: A `sleep` pulse sets `halted` on the next edge. An acknowledge while `sel_valid` is high clears it.
- R10: While halted with `exit_ctl`=1, the selection is the lowest-indexed bit of pending AND `wake_mask`, and the normal chain is ignored.
- R11: While halted with `exit_ctl`=0, any pending source qualifies under its rule with the effective enable forced to 1.
- R12: An acknowledge taken while halted, with `exit_ctl`=0 and `ext_en`=0, clears no pending bit and raises `wake_skip` for exactly the next cycle. Every other acknowledge leaves `wake_skip` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NUM_SRC | Per-source request pulses |
| ack | input | 1 | Core takes the current selection |
| sleep | input | 1 | Enter power-saving state |
| ext_en | input | 1 | External-enable state bit |
| hyp_state | input | 1 | Hypervisor-state bit |
| prob_state | input | 1 | Problem-state bit |
| resume_reset | input | 1 | Resume-as-reset flag |
| hdec_enable | input | 1 | Hypervisor decrementer enable |
| hvirt_enable | input | 1 | Hypervisor virtualisation enable |
| ext_hyp_block | input | 1 | Block external delivery to hypervisor |
| ext_route_os | input | 1 | External routing bit (0 routes to hypervisor) |
| exit_ctl | input | 1 | Power-save exit control |
| wake_mask | input | NUM_SRC | Per-source wake enable used when exit_ctl=1 |
| sel_valid | output | 1 | A source is selected |
| sel_code | output | $clog2(NUM_SRC) | Index of selected source |
| pending | output | NUM_SRC | Pending request vector |
| halted | output | 1 | Power-saving state |
| wake_skip | output | 1 | Wake without delivery occurred |

## Verification
The bench builds the block with NUM_SRC=6 and HAS_HV=1. This gives a single generic low-priority source below the decrementer, so the end of the chain is exercised. It also makes the second, routing-based path of the external rule reachable. With six sources the code is three bits wide, so the tail of the encoder and the zero code for "none" are both observed. Every gating path is then driven both open and closed, as are both halted variants and the wake-without-delivery case.

// File: rtl/irq_prio_wake_pkg.sv
package irq_prio_wake_pkg;
  localparam int SRC_MCHK  = 0;
  localparam int SRC_HDEC  = 1;
  localparam int SRC_HVIRT = 2;
  localparam int SRC_EXT   = 3;
  localparam int SRC_DEC   = 4;
  localparam int SRC_FIXED = 5;

  typedef struct packed {
    logic ext_en;
    logic hyp;
    logic prob;
    logic resume;
  } core_state_t;

  typedef struct packed {
    logic hdec_en;
    logic hvirt_en;
    logic ext_block;
    logic ext_route;
  } part_ctl_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pend_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             pend_q[i] <= 1'b0;
      else if (set_vec[i]) pend_q[i] <= 1'b1;
      else if (clr_vec[i]) pend_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_gate_pick.sv
module irq_gate_pick
  import irq_prio_wake_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter bit HAS_HV  = 1'b1,
  localparam int CW     = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] wake_mask,
  input  core_state_t        cst,
  input  part_ctl_t          pctl,
  input  logic               halted,
  input  logic               exit_ctl,
  output logic               any,
  output logic [CW-1:0]      idx
);
  logic               eff_en;
  logic               ext_blocked;
  logic               ext_direct;
  logic               wake_mode;
  logic [NUM_SRC-1:0] gate;
  logic [NUM_SRC-1:0] cand;

  assign eff_en      = cst.ext_en | cst.resume | (halted & ~exit_ctl);
  assign ext_blocked = pctl.ext_block & cst.hyp & ~cst.prob;
  assign ext_direct  = HAS_HV & ~cst.hyp & ~pctl.ext_route;
  assign wake_mode   = halted & exit_ctl;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    if (i == SRC_MCHK) begin : g_mchk
      assign gate[i] = 1'b1;
    end else if (i == SRC_HDEC) begin : g_hdec
      assign gate[i] = pctl.hdec_en & (eff_en | ~cst.hyp);
    end else if (i == SRC_HVIRT) begin : g_hvirt
      assign gate[i] = pctl.hvirt_en & (eff_en | ~cst.hyp);
    end else if (i == SRC_EXT) begin : g_ext
      assign gate[i] = (eff_en & ~ext_blocked) | ext_direct;
    end else begin : g_low
      assign gate[i] = eff_en;
    end
  end

  assign cand = wake_mode ? (pend & wake_mask) : (pend & gate);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = CW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_wake.sv
module irq_prio_wake
  import irq_prio_wake_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter bit HAS_HV  = 1'b1,
  localparam int CW     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_set,
  input  logic               ack,
  input  logic               sleep,
  input  logic               ext_en,
  input  logic               hyp_state,
  input  logic               prob_state,
  input  logic               resume_reset,
  input  logic               hdec_enable,
  input  logic               hvirt_enable,
  input  logic               ext_hyp_block,
  input  logic               ext_route_os,
  input  logic               exit_ctl,
  input  logic [NUM_SRC-1:0] wake_mask,
  output logic               sel_valid,
  output logic [CW-1:0]      sel_code,
  output logic [NUM_SRC-1:0] pending,
  output logic               halted,
  output logic               wake_skip
);
  core_state_t        cst;
  part_ctl_t          pctl;
  logic               pick_any;
  logic [CW-1:0]      pick_idx;
  logic               take;
  logic               skip_now;
  logic [NUM_SRC-1:0] clr_vec;

  assign cst  = '{ext_en: ext_en, hyp: hyp_state, prob: prob_state, resume: resume_reset};
  assign pctl = '{hdec_en: hdec_enable, hvirt_en: hvirt_enable,
                  ext_block: ext_hyp_block, ext_route: ext_route_os};

  assign take     = ack & sel_valid;
  assign skip_now = take & halted & ~exit_ctl & ~ext_en;

  always_comb begin
    clr_vec = '0;
    if (take && !skip_now) clr_vec[sel_code] = 1'b1;
  end

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_vec (req_set),
    .clr_vec (clr_vec),
    .pend_q  (pending)
  );

  irq_gate_pick #(.NUM_SRC(NUM_SRC), .HAS_HV(HAS_HV)) u_pick (
    .pend      (pending),
    .wake_mask (wake_mask),
    .cst       (cst),
    .pctl      (pctl),
    .halted    (halted),
    .exit_ctl  (exit_ctl),
    .any       (pick_any),
    .idx       (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_code  <= '0;
      halted    <= 1'b0;
      wake_skip <= 1'b0;
    end else begin
      sel_valid <= pick_any;
      sel_code  <= pick_any ? pick_idx : '0;
      wake_skip <= skip_now;
      if (sleep)     halted <= 1'b1;
      else if (take) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_wake_chk.sv
module irq_prio_wake_chk #(
  parameter int NUM_SRC = 8,
  localparam int CW     = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_set,
  input logic               sleep,
  input logic               exit_ctl,
  input logic               sel_valid,
  input logic [CW-1:0]      sel_code,
  input logic [NUM_SRC-1:0] pending,
  input logic               halted,
  input logic               wake_skip
);
  // R1
  req_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (req_set != '0) |=> ((pending & $past(req_set)) == $past(req_set)));

  // R2
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_valid |-> (sel_code == '0));

  // R3
  mchk_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (pending[0] && !(halted && exit_ctl)) |=> (sel_valid && sel_code == '0));

  // R9
  sleep_halts_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> halted);

  // R12
  skip_keeps_pending_chk: assert property (@(posedge clk) disable iff (rst)
    wake_skip |-> (pending == ($past(pending) | $past(req_set))));

  // R12
  skip_leaves_halt_chk: assert property (@(posedge clk) disable iff (rst)
    wake_skip |-> ($past(halted) && !$past(exit_ctl)));
endmodule

bind irq_prio_wake irq_prio_wake_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_set   (req_set),
  .sleep     (sleep),
  .exit_ctl  (exit_ctl),
  .sel_valid (sel_valid),
  .sel_code  (sel_code),
  .pending   (pending),
  .halted    (halted),
  .wake_skip (wake_skip)
);

// File: tb/irq_prio_wake_tb.sv
module irq_prio_wake_tb;
  localparam int N  = 6;
  localparam int CW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_set = '0, wake_mask = '0;
  logic ack = 0, sleep = 0, ext_en = 0, hyp_state = 0, prob_state = 0, resume_reset = 0;
  logic hdec_enable = 0, hvirt_enable = 0, ext_hyp_block = 0, ext_route_os = 0, exit_ctl = 0;
  logic sel_valid, halted, wake_skip;
  logic [CW-1:0] sel_code;
  logic [N-1:0] pending;

  always #5 clk = ~clk;

  irq_prio_wake #(.NUM_SRC(N), .HAS_HV(1'b1)) u_dut (
    .clk(clk), .rst(rst), .req_set(req_set), .ack(ack), .sleep(sleep),
    .ext_en(ext_en), .hyp_state(hyp_state), .prob_state(prob_state),
    .resume_reset(resume_reset), .hdec_enable(hdec_enable),
    .hvirt_enable(hvirt_enable), .ext_hyp_block(ext_hyp_block),
    .ext_route_os(ext_route_os), .exit_ctl(exit_ctl), .wake_mask(wake_mask),
    .sel_valid(sel_valid), .sel_code(sel_code), .pending(pending),
    .halted(halted), .wake_skip(wake_skip)
  );

  typedef struct {
    int          due;
    logic        v;
    logic [CW-1:0] code;
    logic        halt;
    logic [N-1:0] pend;
    logic        ws;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [N-1:0] m_pend = '0;
  logic m_halt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(posedge clk);
    #2;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (sel_valid !== e.v || sel_code !== e.code || halted !== e.halt ||
          pending !== e.pend || wake_skip !== e.ws) begin
        n_bad++;
        $display("FAIL %s: got v=%0b code=%0d halt=%0b pend=%b ws=%0b exp v=%0b code=%0d halt=%0b pend=%b ws=%0b",
                 e.tag, sel_valid, sel_code, halted, pending, wake_skip,
                 e.v, e.code, e.halt, e.pend, e.ws);
      end
    end
  end

  task automatic push(input logic v, input int code, input logic ws, input string tag);
    exp_t e;
    e.due = cyc + 1; e.v = v; e.code = CW'(code); e.halt = m_halt;
    e.pend = m_pend; e.ws = ws; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle_chk(input logic v, input int code, input string tag);
    repeat (3) @(negedge clk);
    push(v, code, 1'b0, tag);
    @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    @(negedge clk);
    req_set = m;
    m_pend |= m;
    @(negedge clk);
    req_set = '0;
  endtask

  task automatic do_sleep();
    @(negedge clk);
    sleep = 1'b1;
    m_halt = 1'b1;
    @(negedge clk);
    sleep = 1'b0;
  endtask

  // ack the current selection; v/code are the selection still shown one cycle later
  task automatic do_ack(input int code, input logic skip, input logic [N-1:0] also_set,
                        input string tag);
    @(negedge clk);
    ack = 1'b1;
    req_set = also_set;
    if (!skip) m_pend[code] = 1'b0;
    m_pend |= also_set;
    m_halt = 1'b0;
    push(1'b1, code, skip, tag);
    @(negedge clk);
    ack = 1'b0;
    req_set = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle_chk(1'b0, 0, "R2 reset state");

    // R8: decrementer and low source with enable open
    @(negedge clk); ext_en = 1'b1;
    pulse_req(6'b110000);
    settle_chk(1'b1, 4, "R8 dec over low source");
    @(negedge clk); ext_en = 1'b0;
    settle_chk(1'b0, 0, "R8 dec gated by enable");
    @(negedge clk); ext_en = 1'b1;

    // R5: hypervisor decrementer enable
    pulse_req(6'b000010);
    settle_chk(1'b1, 4, "R5 hdec disabled");
    @(negedge clk); hdec_enable = 1'b1;
    settle_chk(1'b1, 1, "R5 hdec enabled");

    // R3: machine check regardless of enables
    pulse_req(6'b000001);
    settle_chk(1'b1, 0, "R3 mchk highest");
    @(negedge clk); ext_en = 1'b0; hyp_state = 1'b1;
    settle_chk(1'b1, 0, "R3 mchk with enables off");
    do_ack(0, 1'b0, '0, "R1 ack clears mchk");
    settle_chk(1'b0, 0, "R5 hdec held in hyp with enable off");
    @(negedge clk); resume_reset = 1'b1;
    settle_chk(1'b1, 1, "R4 resume opens enable");
    @(negedge clk); resume_reset = 1'b0; hyp_state = 1'b0;
    settle_chk(1'b1, 1, "R5 hdec outside hyp state");
    do_ack(1, 1'b0, '0, "R1 ack clears hdec");
    settle_chk(1'b0, 0, "R8 low sources gated");

    // R6: hvirt follows the same rule
    pulse_req(6'b000100);
    settle_chk(1'b0, 0, "R6 hvirt disabled");
    @(negedge clk); hvirt_enable = 1'b1;
    settle_chk(1'b1, 2, "R6 hvirt enabled");
    do_ack(2, 1'b0, '0, "R6 ack hvirt");

    // R7: external paths
    pulse_req(6'b001000);
    settle_chk(1'b1, 3, "R7 routed to hypervisor");
    @(negedge clk); ext_route_os = 1'b1;
    settle_chk(1'b0, 0, "R7 routing bit set, enable off");
    @(negedge clk); ext_en = 1'b1; hyp_state = 1'b1; prob_state = 1'b0; ext_hyp_block = 1'b1;
    settle_chk(1'b1, 4, "R7 blocked in hyp");
    @(negedge clk); prob_state = 1'b1;
    settle_chk(1'b1, 3, "R7 unblocked in problem state");

    // R1: set and clear in one cycle resolve to set
    do_ack(3, 1'b0, 6'b001000, "R1 set wins over clear");
    settle_chk(1'b1, 3, "R1 ext still selected");
    do_ack(3, 1'b0, '0, "R1 ext cleared");
    settle_chk(1'b1, 4, "R2 next priority dec");
    do_ack(4, 1'b0, '0, "R1 dec cleared");
    settle_chk(1'b1, 5, "R2 low source last");
    do_ack(5, 1'b0, '0, "R1 low cleared");
    settle_chk(1'b0, 0, "R2 empty");

    // R10: halted with exit control uses wake mask
    @(negedge clk); exit_ctl = 1'b1; wake_mask = '0;
    do_sleep();
    settle_chk(1'b0, 0, "R9 halted idle");
    pulse_req(6'b010000);
    settle_chk(1'b0, 0, "R10 masked off while halted");
    @(negedge clk); wake_mask = 6'b010000;
    settle_chk(1'b1, 4, "R10 wake mask selects");
    pulse_req(6'b000001);
    settle_chk(1'b1, 4, "R10 chain skipped for mchk");
    do_ack(4, 1'b0, '0, "R9 ack leaves halted");
    settle_chk(1'b1, 0, "R3 mchk after wake");
    do_ack(0, 1'b0, '0, "R1 mchk cleared");

    // R11/R12: exit control clear, enable off
    @(negedge clk); exit_ctl = 1'b0; ext_en = 1'b0; wake_mask = '0;
    do_sleep();
    pulse_req(6'b010000);
    settle_chk(1'b1, 4, "R11 forced enable while halted");
    do_ack(4, 1'b1, '0, "R12 wake without delivery");
    settle_chk(1'b0, 0, "R12 pending kept, gated again");

    // R12: enable on, normal delivery from halt
    @(negedge clk); ext_en = 1'b1;
    settle_chk(1'b1, 4, "R8 dec with enable on");
    do_sleep();
    settle_chk(1'b1, 4, "R11 halted with enable on");
    do_ack(4, 1'b0, '0, "R12 delivered, no skip");
    settle_chk(1'b0, 0, "R9 back to run, empty");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule